// File: doc/BRIEF.md
# Multidrop Serial Port with Address Filtering

This block is an asynchronous, full-duplex serial port for a multidrop link. A host reaches it through a small register interface. Writing the data address starts a transmission, and reading the same address returns the last byte kept by the receiver. Received bytes move into a holding register, so the next frame can start arriving before the host has read the previous one. Frames carry eight data bits, or nine when nine-bit mode is selected. An external enable, `baud_tick`, paces both directions at sixteen ticks per bit.

In nine-bit mode with address filtering enabled, the receiver keeps only frames that carry address traffic for this node. Such a frame has its ninth bit set and either matches the node address in every bit the mask enables, or is the all-ones broadcast value. Other frames are dropped without a trace. The status flags for receive-done, transmit-done, overrun, frame error and transmit collision stay set until the host writes a zero to them. The interrupt output is active while either completion flag is set.

Register map, selected by `host_addr`:
- 0 = data
- 1 = control: bit0 nine-bit mode, bit1 address filter enable, bit2 ninth bit to send
- 2 = status: bit0 receive done, bit1 transmit done, bit2 overrun, bit3 frame error, bit4 transmit collision, bit5 received ninth bit (read-only)
- 3 = node address
- 4 = address mask

Top module: `mpuart`

## Requirements
- R1: After reset `txd` is 1, every status bit reads 0 and `irq` is 0.
- R2: A write to address 0 sends these bits on `txd`, each lasting 16 `baud_tick` pulses: a 0 start bit, then the eight data bits least significant first, then (in nine-bit mode only) control bit2, then a 1 stop bit.
- R3: Status bit1 sets when the stop bit has been sent. A write to address 0 while a frame is still going out sets status bit4 and is discarded, so no further frame follows.
- R4: Each bit of an incoming frame is sampled at its middle. An accepted frame puts its byte at address 0 and sets status bit0. In nine-bit mode, status bit5 holds the received ninth bit.
- R5: If a frame is accepted while the previous byte has not been read from address 0, status bit2 sets and address 0 returns the new byte.
- R6: A stop bit sampled as 0 sets status bit3. The byte is still delivered.
- R7: A low pulse on `rxd` that is gone by the middle of the start bit is ignored. Status bit0 stays 0 and address 0 keeps its old value.
- R8: With nine-bit mode and filtering both on, a frame whose ninth bit is 0 is dropped. It leaves address 0 and status bit0 unchanged.
- R9: With filtering on, a frame with ninth bit 1 is accepted when its byte ANDed with the mask equals the node address ANDed with the mask. Otherwise it is dropped.
- R10: With filtering on, the nine-bit value 0x1FF is accepted whatever the node address and mask.
- R11: Status bits 0 to 4 stay set until the host writes 0 to them at address 2. Writing 1 leaves a bit as it is.
- R12: `irq` equals status bit0 OR status bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit time |
| host_addr | input | 3 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (marks the data byte as read) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Completion interrupt |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The hardest case to reach from the ports is the set of frames that must leave no trace. These are frames dropped by the filter and start pulses that vanish before mid-bit. A dropped frame can only be seen as a flag that did not set and a holding byte that did not change. The bench therefore plants a known byte in the holding register first, then drives each frame bit by bit on `rxd` with its own ninth bit. The vector table covers data frames, masked hits and misses, and broadcast frames. After each one it reads back both the flag and the byte. The glitch case drives a quarter-bit low pulse and then sends a clean frame, to show that the receiver returns to idle rather than staying stuck.

// File: rtl/mpuart_pkg.sv
// Shared register addresses, status bit positions and receiver states.
package mpuart_pkg;
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_NODE = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;

    localparam int S_RXD  = 0;
    localparam int S_TXD  = 1;
    localparam int S_OVR  = 2;
    localparam int S_FERR = 3;
    localparam int S_COLL = 4;
    localparam int S_RB8  = 5;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    typedef struct packed {
        logic tx_b8;
        logic mp_en;
        logic nine;
    } ctrl_t;
endpackage

// File: rtl/mpuart_tx.sv
// Transmit shifter: sends start, DW data bits LSB first, optional ninth bit
// and stop. Each bit lasts OVS ticks. A load is taken only while idle.
// Assumes tick is a one-cycle enable.
module mpuart_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          nine,
    input  logic          b8,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FW + 1);

    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [BW-1:0] left;

    // Frame loading, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                sh   <= {1'b1, (nine ? b8 : 1'b1), din, 1'b0};
                cnt  <= '0;
                left <= nine ? BW'(FW) : BW'(FW - 1);
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt  <= '0;
                    sh   <= {1'b1, sh[FW-1:1]};
                    left <= left - BW'(1);
                    if (left == BW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // Line drive: idle high, else the current frame bit.
    always_comb txd = busy ? sh[0] : 1'b1;

    // R3
    tx_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (txd == 1'b0));
endmodule

// File: rtl/mpuart_rx.sv
// Receive shifter: synchronises rxd, finds a falling edge at tick rate,
// confirms the start bit at mid-bit, then samples the data bits, the
// optional ninth bit and the stop bit at mid-bit. It pulses fdone with the
// frame contents. Assumes tick is a one-cycle enable, OVS per bit.
module mpuart_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          nine,
    output logic          fdone,
    output logic [DW-1:0] fdata,
    output logic          fb8,
    output logic          fstop
);
    import mpuart_pkg::*;
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW + 1);

    logic [1:0]    sync;
    logic          line;
    logic          prev;
    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW:0]   sh;

    // Two-flop synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end
    always_comb line = sync[1];

    // Frame state machine, stepped on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            prev  <= 1'b1;
            fdone <= 1'b0;
            fstop <= 1'b1;
        end else begin
            fdone <= 1'b0;
            if (tick) begin
                prev <= line;
                unique case (st)
                    RX_IDLE: begin
                        if (prev && !line) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(OVS / 2 - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            sh  <= '0;
                            st  <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt     <= '0;
                            sh[idx] <= line;
                            idx     <= idx + IW'(1);
                            if (idx == (nine ? IW'(DW) : IW'(DW - 1)))
                                st <= RX_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt   <= '0;
                            fstop <= line;
                            fdone <= 1'b1;
                            st    <= RX_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // Frame fields seen by the filter and holding logic.
    always_comb begin
        fdata = sh[DW-1:0];
        fb8   = nine & sh[DW];
    end

    // R7
    rx_glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && tick && cnt == CW'(OVS / 2 - 1) && line) |=> (st == RX_IDLE));
    // R4
    rx_done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fdone |-> $past(st == RX_STOP));
endmodule

// File: rtl/mpuart_match.sv
// Address filter: a hit is a frame with ninth bit 1 whose byte matches the
// node address in every bit the mask enables, or the all-ones broadcast.
// Purely combinational.
module mpuart_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          b8,
    input  logic [DW-1:0] node,
    input  logic [DW-1:0] mask,
    output logic          hit
);
    logic own;
    logic bcast;

    // Masked own-address and broadcast compare.
    always_comb begin
        own   = ((data & mask) == (node & mask));
        bcast = &data;
        hit   = b8 & (own | bcast);
    end
endmodule

// File: rtl/mpuart.sv
// Multidrop serial port top: host registers, frame acceptance, holding
// register and sticky flags. Assumes single-cycle host strobes and a
// combinational read path.
module mpuart #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq,
    output logic          txd,
    input  logic          rxd
);
    import mpuart_pkg::*;

    ctrl_t         ctrl;
    logic [DW-1:0] node, mask, hold;
    logic          f_rxd, f_txd, f_ovr, f_ferr, f_coll, rb8, unread;
    logic          tx_load, tx_busy, tx_done;
    logic          fdone, fb8, fstop, hit, accept;
    logic [DW-1:0] fdata;

    always_comb tx_load = host_wr && (host_addr == A_DATA);

    mpuart_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(tx_load),
        .din(host_wdata), .nine(ctrl.nine), .b8(ctrl.tx_b8),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    mpuart_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .nine(ctrl.nine),
        .fdone(fdone), .fdata(fdata), .fb8(fb8), .fstop(fstop)
    );

    mpuart_match #(.DW(DW)) u_match (
        .data(fdata), .b8(fb8), .node(node), .mask(mask), .hit(hit)
    );

    // Acceptance: filter applies only in nine-bit mode with filtering on.
    always_comb accept = fdone && (!(ctrl.nine && ctrl.mp_en) || hit);

    // Control and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            node <= '0;
            mask <= '0;
        end else if (host_wr) begin
            if (host_addr == A_CTRL) ctrl <= ctrl_t'(host_wdata[2:0]);
            if (host_addr == A_NODE) node <= host_wdata;
            if (host_addr == A_MASK) mask <= host_wdata;
        end
    end

    // Sticky flags and holding register; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {f_rxd, f_txd, f_ovr, f_ferr, f_coll, rb8, unread} <= '0;
            hold <= '0;
        end else begin
            if (host_wr && host_addr == A_STAT) begin
                f_rxd  <= f_rxd  & host_wdata[S_RXD];
                f_txd  <= f_txd  & host_wdata[S_TXD];
                f_ovr  <= f_ovr  & host_wdata[S_OVR];
                f_ferr <= f_ferr & host_wdata[S_FERR];
                f_coll <= f_coll & host_wdata[S_COLL];
            end
            if (host_rd && host_addr == A_DATA) unread <= 1'b0;
            if (tx_load && tx_busy) f_coll <= 1'b1;
            if (tx_done) f_txd <= 1'b1;
            if (accept) begin
                hold   <= fdata;
                rb8    <= fb8;
                f_rxd  <= 1'b1;
                unread <= 1'b1;
                if (unread) f_ovr  <= 1'b1;
                if (!fstop) f_ferr <= 1'b1;
            end
        end
    end

    // Read mux and interrupt.
    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_DATA: host_rdata = hold;
            A_CTRL: host_rdata = DW'(ctrl);
            A_STAT: host_rdata = DW'({rb8, f_coll, f_ferr, f_ovr, f_txd, f_rxd});
            A_NODE: host_rdata = node;
            A_MASK: host_rdata = mask;
            default: host_rdata = '0;
        endcase
        irq = f_rxd | f_txd;
    end

    // R3
    tx_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_busy) |=> f_coll);
    // R5
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && unread) |=> (f_ovr && hold == $past(fdata)));
    // R6
    frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fstop) |=> f_ferr);
    // R8
    mp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdone && ctrl.nine && ctrl.mp_en && !fb8 && !(host_wr && host_addr == A_STAT))
        |=> ($stable(hold) && f_rxd == $past(f_rxd)));
    // R10
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdone && ctrl.nine && fb8 && (&fdata)) |=> (f_rxd && &hold));
endmodule

// File: tb/mpuart_tb.sv
module mpuart_tb;
    localparam int BIT = 64;  // clocks per bit: 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq, txd;
    logic       rxd = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    mpuart u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq), .txd(txd), .rxd(rxd)
    );

    always #4 clk = ~clk;

    // Tick generator: one pulse every 4 clocks.
    initial begin
        forever begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                baud_tick = (k == 3);
            end
        end
    end

    // {nine, mp, node, mask, b8, data, accept}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'hA5, 1'b1},  // R4 eight-bit
        {1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h3C, 1'b1},  // R4 nine-bit, no filter
        {1'b1, 1'b1, 8'h12, 8'hFF, 1'b0, 8'h55, 1'b0},  // R8 data frame dropped
        {1'b1, 1'b1, 8'h12, 8'hFF, 1'b1, 8'h12, 1'b1},  // R9 exact hit
        {1'b1, 1'b1, 8'h12, 8'hFF, 1'b1, 8'h13, 1'b0},  // R9 miss
        {1'b1, 1'b1, 8'h12, 8'hF0, 1'b1, 8'h1F, 1'b1},  // R9 masked hit
        {1'b1, 1'b1, 8'h12, 8'hFF, 1'b1, 8'hFF, 1'b1},  // R10 broadcast
        {1'b1, 1'b1, 8'h12, 8'hFF, 1'b0, 8'hFF, 1'b0}   // R8 ninth bit 0
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_rd = (a == 3'd0);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic send(input bit nine, input bit b8, input logic [7:0] d, input bit stop);
        @(negedge clk); rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (nine) begin
            rxd = b8;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, exp_hold;
        logic [10:0] cap;
        bit quiet;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v);
        check(v == 8'h00, "R1 status", v, 0);
        check(txd == 1'b1 && irq == 1'b0, "R1 txd/irq", {txd, irq}, 2);

        // Vector table
        exp_hold = 8'h00;
        for (int n = 0; n < 8; n++) begin
            wr(3'd1, {6'b0, VEC[n][26], VEC[n][27]});
            wr(3'd3, VEC[n][25:18]);
            wr(3'd4, VEC[n][17:10]);
            wr(3'd2, 8'h00);
            rd(3'd0, v);
            send(VEC[n][27], VEC[n][9], VEC[n][8:1], 1'b1);
            if (VEC[n][0]) exp_hold = VEC[n][8:1];
            rd(3'd2, v);
            check(v[0] == VEC[n][0], "R4/R8/R9/R10 rx_done", v[0], VEC[n][0]);
            check(irq == VEC[n][0], "R12 irq", irq, VEC[n][0]);
            if (VEC[n][0] && VEC[n][27])
                check(v[5] == VEC[n][9], "R4 ninth bit", v[5], VEC[n][9]);
            rd(3'd0, v);
            check(v == exp_hold, "R4/R8/R9 holding byte", v, exp_hold);
        end

        // R5 overrun
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); rd(3'd0, v);
        send(1'b0, 1'b0, 8'h11, 1'b1);
        rd(3'd2, v);
        check(v[2] == 1'b0, "R5 no overrun after one", v[2], 0);
        send(1'b0, 1'b0, 8'h22, 1'b1);
        rd(3'd2, v);
        check(v[2] == 1'b1, "R5 overrun", v[2], 1);
        rd(3'd0, v);
        check(v == 8'h22, "R5 newest byte", v, 8'h22);

        // R6 frame error
        wr(3'd2, 8'h00); rd(3'd0, v);
        send(1'b0, 1'b0, 8'h5A, 1'b0);
        rd(3'd2, v);
        check(v[3] == 1'b1 && v[0] == 1'b1, "R6 frame error", v, 8'h09);
        rd(3'd0, v);
        check(v == 8'h5A, "R6 byte delivered", v, 8'h5A);

        // R7 start glitch
        wr(3'd2, 8'h00);
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (20 * BIT) @(negedge clk);
        rd(3'd2, v);
        check(v[0] == 1'b0, "R7 glitch ignored", v[0], 0);
        rd(3'd0, v);
        check(v == 8'h5A, "R7 holding unchanged", v, 8'h5A);
        send(1'b0, 1'b0, 8'h77, 1'b1);
        rd(3'd0, v);
        check(v == 8'h77, "R7 recovery", v, 8'h77);

        // R2 transmit frame, nine-bit with ninth bit 1
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h05);
        wr(3'd0, 8'h96);
        while (txd) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            cap[i] = txd;
            if (i < 10) repeat (BIT) @(negedge clk);
        end
        check(cap == {1'b1, 1'b1, 8'h96, 1'b0}, "R2 tx frame", cap, {1'b1, 1'b1, 8'h96, 1'b0});
        repeat (BIT) @(negedge clk);
        rd(3'd2, v);
        check(v[1] == 1'b1, "R3 tx_done", v[1], 1);
        check(irq == 1'b1, "R12 irq from tx", irq, 1);

        // R3 collision: second write discarded
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h0F);
        repeat (100) @(negedge clk);
        wr(3'd0, 8'hAA);
        rd(3'd2, v);
        check(v[4] == 1'b1, "R3 collision", v[4], 1);
        repeat (12 * BIT) @(negedge clk);
        quiet = 1'b1;
        for (int i = 0; i < 12 * BIT; i++) begin
            @(negedge clk);
            if (!txd) quiet = 1'b0;
        end
        check(quiet, "R3 write discarded", quiet, 1);

        // R11 write-one keeps, write-zero clears
        rd(3'd2, v);
        check(v[1:0] == 2'b10 && v[4], "R11 flags held", v, 8'h12);
        wr(3'd2, 8'hFF);
        rd(3'd2, v);
        check(v[4] && v[1], "R11 write one no effect", v, 8'h12);
        wr(3'd2, 8'hFD);
        rd(3'd2, v);
        check(!v[1] && v[4], "R11 clear tx_done only", v, 8'h10);
        check(irq == 1'b0, "R12 irq low", irq, 0);
        wr(3'd2, 8'h00);
        rd(3'd2, v);
        check(v[4:0] == 5'b0, "R11 all cleared", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule